// File: doc/BRIEF.md
# Packet Word Framer with Byte-Lane Qualifier

This block turns packets from an upstream buffer into a stream of 64-bit bus words. A 4-bit qualifier travels with each bus word and gives that word's role: idle, first word of a packet, middle word, final word, or one of the two trailing status words. On a final word the qualifier also carries the number of valid bytes. A mode input selects little-endian or big-endian byte-lane placement for partial final words and for status words. Unused lanes are driven to zero.

The consumer pulls words with a read strobe. In each cycle where the strobe is high, the framer retires the word it is showing and loads the next one. With the strobe low, the bus holds its value. Upstream offers one word at a time with a last flag and a byte count. The two 32-bit status values are presented together with the last word. A word is taken in any cycle where both `inValid` and `inReady` are high.

Top module: `pkt_word_framer`

## Requirements
- R1: A synchronous active-high reset, applied at any point including mid-packet, drives `busQual` to 0000 and `busData` to zero. The next packet after reset starts with qualifier 0001.
- R2: While `rdStrobe` is low, `busQual` and `busData` keep their values.
- R3: In a packet of two or more words, the first word is shown with qualifier 0001 and all 64 bits of the input word.
- R4: Each word between the first and the last is shown with qualifier 0010 and all 64 bits.
- R5: The last data word is shown with qualifier 1nnn, where nnn equals `inBytes`. An `inBytes` value of 0 means all eight bytes are valid.
- R6: With `bigEndian` low, a final word with n valid bytes (1 to 7) keeps bytes 0 to n-1, which start at bit 0, and zeroes the other bytes.
- R7: With `bigEndian` high, a final word with n valid bytes keeps the top n bytes, which end at bit 63, and zeroes the other bytes.
- R8: A packet of one word is shown as a single final word with qualifier 1nnn and no start word.
- R9: After the final word, the next two strobes show 0100 with `statFirst` and then 0101 with `statLast`. In little-endian mode the status value sits in bits [31:0]; in big-endian mode it sits in bits [63:32]. The other half is zero.
- R10: Qualifier 0000 always comes with all-zero data. The codes 0011, 0110 and 0111 never appear.
- R11: If a strobe comes in the middle of a packet while `inValid` is low, the framer shows 0000 with zero data. The packet then continues with 0010 or 1nnn. It never restarts with 0001.
- R12: `inReady` is high only in a cycle where `rdStrobe` is high and the framer is idle, inside a packet, or showing the last status word. While a final word or the first status word is being shown, no input word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bigEndian | input | 1 | Lane placement mode: 1 puts valid bytes at the high end |
| inWord | input | 64 | Upstream data word |
| inValid | input | 1 | Upstream word is present |
| inLast | input | 1 | Upstream word ends its packet |
| inBytes | input | 3 | Valid bytes in the last word, 0 meaning eight |
| statFirst | input | 32 | First status value, sampled along with the last word |
| statLast | input | 32 | Second status value, sampled along with the last word |
| inReady | output | 1 | Framer takes the upstream word this cycle |
| rdStrobe | input | 1 | Consumer retires the current bus word |
| busData | output | 64 | Bus data word |
| busQual | output | 4 | Word qualifier code |

## Verification
Every bus result is registered. `busQual` and `busData` change on the rising edge where `rdStrobe` is high and can be read one cycle after the strobe is driven. `inReady` depends on the strobe and on the current state within the same cycle, before the edge. The bench applies inputs at the falling edge and reads `inReady` 1 ns later. It reads the bus 1 ns after the next rising edge, so each expected value is compared in the exact cycle it becomes due. Cycles with the strobe low are mixed into the sequence, so the check of held outputs falls on the same sample points.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

  // Qualifier codes; the end code is {1'b1, byteCount}
  localparam logic [3:0] Q_IDLE  = 4'b0000;
  localparam logic [3:0] Q_START = 4'b0001;
  localparam logic [3:0] Q_INTER = 4'b0010;
  localparam logic [3:0] Q_STATA = 4'b0100;
  localparam logic [3:0] Q_STATB = 4'b0101;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeWord;
    logic isEnd;
    logic grabStatus;
    logic showStatA;
    logic showStatB;
    logic showIdle;
  } pwf_ctl_t;

  // What the bus is currently showing
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_END,
    ST_STATA,
    ST_STATB
  } pwf_state_t;

endpackage

// File: rtl/pwf_ctrl.sv
module pwf_ctrl
  import pwf_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdStrobe,
  input  logic             inValid,
  input  logic             inLast,
  input  logic [CNT_W-1:0] inBytes,
  output logic             inReady,
  output pwf_ctl_t         ctl,
  output logic [CNT_W:0]   busQual
);

  localparam int QW = CNT_W + 1;

  pwf_state_t state, stateNext;
  logic [QW-1:0] qualReg, qualNext;
  logic wantData;

  assign wantData = (state == ST_IDLE) || (state == ST_BODY) || (state == ST_STATB);
  assign inReady  = rdStrobe && wantData;
  assign busQual  = qualReg;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    qualNext  = qualReg;
    if (rdStrobe) begin
      unique case (state)
        ST_IDLE, ST_STATB, ST_BODY: begin
          if (inValid) begin
            ctl.takeWord   = 1'b1;
            ctl.isEnd      = inLast;
            ctl.grabStatus = inLast;
            if (inLast) begin
              qualNext  = {1'b1, inBytes};
              stateNext = ST_END;
            end else begin
              qualNext  = (state == ST_BODY) ? QW'(Q_INTER) : QW'(Q_START);
              stateNext = ST_BODY;
            end
          end else begin
            ctl.showIdle = 1'b1;
            qualNext     = QW'(Q_IDLE);
            stateNext    = (state == ST_BODY) ? ST_BODY : ST_IDLE;
          end
        end
        ST_END: begin
          ctl.showStatA = 1'b1;
          qualNext      = QW'(Q_STATA);
          stateNext     = ST_STATA;
        end
        ST_STATA: begin
          ctl.showStatB = 1'b1;
          qualNext      = QW'(Q_STATB);
          stateNext     = ST_STATB;
        end
        default: begin
          ctl.showIdle = 1'b1;
          qualNext     = QW'(Q_IDLE);
          stateNext    = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      qualReg <= QW'(Q_IDLE);
    end else begin
      state   <= stateNext;
      qualReg <= qualNext;
    end
  end

endmodule

// File: rtl/pwf_lanemask.sv
module pwf_lanemask #(
  parameter int BYTES = 8,
  parameter int CNT_W = 3
) (
  input  logic             bigEndian,
  input  logic             isEnd,
  input  logic [CNT_W-1:0] nBytes,
  output logic [BYTES-1:0] laneOn
);

  localparam int NW = CNT_W + 1;

  logic [NW-1:0] nEff;
  logic [NW-1:0] beFloor;

  assign nEff    = (nBytes == '0) ? NW'(BYTES) : {1'b0, nBytes};
  assign beFloor = NW'(BYTES) - nEff;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneOn[b] = !isEnd ||
                       (bigEndian ? (NW'(b) >= beFloor) : (NW'(b) < nEff));
  end

endmodule

// File: rtl/pwf_dpath.sv
module pwf_dpath
  import pwf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  pwf_ctl_t            ctl,
  input  logic                bigEndian,
  input  logic [DATA_W-1:0]   inWord,
  input  logic [CNT_W-1:0]    inBytes,
  input  logic [DATA_W/2-1:0] statFirst,
  input  logic [DATA_W/2-1:0] statLast,
  output logic [DATA_W-1:0]   busData
);

  localparam int BYTES = DATA_W / 8;
  localparam int HW    = DATA_W / 2;

  logic [BYTES-1:0]  laneOn;
  logic [DATA_W-1:0] maskedWord;
  logic [HW-1:0]     statAReg, statBReg;
  logic [DATA_W-1:0] statAWord, statBWord;
  logic [DATA_W-1:0] dataReg;

  pwf_lanemask #(.BYTES(BYTES), .CNT_W(CNT_W)) lanes_i (
    .bigEndian (bigEndian),
    .isEnd     (ctl.isEnd),
    .nBytes    (inBytes),
    .laneOn    (laneOn)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_mask
    assign maskedWord[8*b +: 8] = laneOn[b] ? inWord[8*b +: 8] : 8'h00;
  end

  assign statAWord = bigEndian ? {statAReg, {HW{1'b0}}} : {{HW{1'b0}}, statAReg};
  assign statBWord = bigEndian ? {statBReg, {HW{1'b0}}} : {{HW{1'b0}}, statBReg};
  assign busData   = dataReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      statAReg <= '0;
      statBReg <= '0;
    end else if (ctl.grabStatus) begin
      statAReg <= statFirst;
      statBReg <= statLast;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
    end else if (ctl.takeWord) begin
      dataReg <= maskedWord;
    end else if (ctl.showStatA) begin
      dataReg <= statAWord;
    end else if (ctl.showStatB) begin
      dataReg <= statBWord;
    end else if (ctl.showIdle) begin
      dataReg <= '0;
    end
  end

endmodule

// File: rtl/pkt_word_framer.sv
module pkt_word_framer
  import pwf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bigEndian,
  input  logic [DATA_W-1:0]   inWord,
  input  logic                inValid,
  input  logic                inLast,
  input  logic [CNT_W-1:0]    inBytes,
  input  logic [DATA_W/2-1:0] statFirst,
  input  logic [DATA_W/2-1:0] statLast,
  output logic                inReady,
  input  logic                rdStrobe,
  output logic [DATA_W-1:0]   busData,
  output logic [CNT_W:0]      busQual
);

  pwf_ctl_t ctl;

  pwf_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .rdStrobe (rdStrobe),
    .inValid  (inValid),
    .inLast   (inLast),
    .inBytes  (inBytes),
    .inReady  (inReady),
    .ctl      (ctl),
    .busQual  (busQual)
  );

  pwf_dpath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .bigEndian (bigEndian),
    .inWord    (inWord),
    .inBytes   (inBytes),
    .statFirst (statFirst),
    .statLast  (statLast),
    .busData   (busData)
  );

endmodule

// File: rtl/pwf_checker.sv
module pwf_checker #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rdStrobe,
  input logic              inReady,
  input logic [DATA_W-1:0] busData,
  input logic [CNT_W:0]    busQual
);

  localparam int HW = DATA_W / 2;

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !rdStrobe |=> ($stable(busQual) && $stable(busData)));

  p_no_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (busQual != 4'b0011) && (busQual != 4'b0110) && (busQual != 4'b0111));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (busQual == 4'b0000) |-> (busData == '0));

  p_end_then_stat_r9: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && busQual[CNT_W]) |=> (busQual == 4'b0100));

  p_stat_order_r9: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && busQual == 4'b0100) |=> (busQual == 4'b0101));

  p_stat_half_r9: assert property (@(posedge clk) disable iff (rst)
    (busQual == 4'b0100 || busQual == 4'b0101) |->
      (busData[DATA_W-1:HW] == '0 || busData[HW-1:0] == '0));

  p_no_take_r12: assert property (@(posedge clk) disable iff (rst)
    (busQual[CNT_W] || busQual == 4'b0100) |-> !inReady);

endmodule

bind pkt_word_framer pwf_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rdStrobe (rdStrobe),
  .inReady  (inReady),
  .busData  (busData),
  .busQual  (busQual)
);

// File: tb/pkt_word_framer_tb_top.sv
module pkt_word_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bigEndian = 1'b0;
  logic [63:0] inWord = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic [2:0]  inBytes = '0;
  logic [31:0] statFirst = 32'hCAFE0001;
  logic [31:0] statLast  = 32'hCAFE0002;
  logic        inReady;
  logic        rdStrobe = 1'b0;
  logic [63:0] busData;
  logic [3:0]  busQual;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  pkt_word_framer dut_i (
    .clk(clk), .rst(rst), .bigEndian(bigEndian), .inWord(inWord),
    .inValid(inValid), .inLast(inLast), .inBytes(inBytes),
    .statFirst(statFirst), .statLast(statLast), .inReady(inReady),
    .rdStrobe(rdStrobe), .busData(busData), .busQual(busQual)
  );

  localparam logic [63:0] DW = 64'h8877_6655_4433_2211;
  localparam logic [63:0] EW = 64'h0102_0304_0506_0708;
  localparam logic [63:0] SLA = 64'h0000_0000_CAFE_0001;
  localparam logic [63:0] SLB = 64'h0000_0000_CAFE_0002;
  localparam logic [63:0] SBA = 64'hCAFE_0001_0000_0000;
  localparam logic [63:0] SBB = 64'hCAFE_0002_0000_0000;

  typedef struct packed {
    logic        s;
    logic        v;
    logic        l;
    logic [2:0]  n;
    logic        be;
    logic [63:0] d;
    logic        rdy;
    logic [3:0]  q;
    logic [63:0] x;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,3'd0,1'b0,DW,1'b0,4'b0000,64'h0,4'd12},                 // R12 R2 no strobe
    '{1'b1,1'b1,1'b0,3'd0,1'b0,DW,1'b1,4'b0001,DW,4'd3},                     // R3 start
    '{1'b0,1'b1,1'b0,3'd0,1'b0,EW,1'b0,4'b0001,DW,4'd2},                     // R2 hold
    '{1'b1,1'b1,1'b0,3'd0,1'b0,EW,1'b1,4'b0010,EW,4'd4},                     // R4 intermediate
    '{1'b1,1'b0,1'b0,3'd0,1'b0,DW,1'b1,4'b0000,64'h0,4'd11},                 // R11 gap
    '{1'b1,1'b1,1'b1,3'd3,1'b0,DW,1'b1,4'b1011,64'h0000_0000_0033_2211,4'd6}, // R5 R6
    '{1'b1,1'b1,1'b0,3'd0,1'b0,DW,1'b0,4'b0100,SLA,4'd9},                    // R9 R12
    '{1'b0,1'b1,1'b0,3'd0,1'b0,DW,1'b0,4'b0100,SLA,4'd2},                    // R2
    '{1'b1,1'b1,1'b0,3'd0,1'b0,DW,1'b0,4'b0101,SLB,4'd9},                    // R9
    '{1'b1,1'b1,1'b1,3'd0,1'b1,DW,1'b1,4'b1000,DW,4'd8},                     // R8 R5 full
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0100,SBA,4'd9},                    // R9 BE
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0101,SBB,4'd9},                    // R9 BE
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b1,4'b0000,64'h0,4'd10},                 // R10 idle
    '{1'b1,1'b1,1'b0,3'd0,1'b1,DW,1'b1,4'b0001,DW,4'd3},                     // R3
    '{1'b1,1'b1,1'b1,3'd3,1'b1,DW,1'b1,4'b1011,64'h8877_6600_0000_0000,4'd7}, // R7
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0100,SBA,4'd9},                    // R9
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0101,SBB,4'd9},                    // R9
    '{1'b1,1'b1,1'b1,3'd7,1'b0,DW,1'b1,4'b1111,64'h0077_6655_4433_2211,4'd6}, // R6 R8
    '{1'b1,1'b0,1'b0,3'd0,1'b0,DW,1'b0,4'b0100,SLA,4'd9},                    // R9
    '{1'b1,1'b0,1'b0,3'd0,1'b0,DW,1'b0,4'b0101,SLB,4'd9},                    // R9
    '{1'b1,1'b0,1'b0,3'd0,1'b0,DW,1'b1,4'b0000,64'h0,4'd10},                 // R10
    '{1'b1,1'b1,1'b1,3'd1,1'b1,DW,1'b1,4'b1001,64'h8800_0000_0000_0000,4'd7}, // R7 R5
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0100,SBA,4'd9},                    // R9
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b0,4'b0101,SBB,4'd9},                    // R9
    '{1'b1,1'b0,1'b0,3'd0,1'b1,DW,1'b1,4'b0000,64'h0,4'd10}                  // R10
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 reset qual", 64'(busQual), 64'h0);
    check("R1 reset data", busData, 64'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rdStrobe  = VECS[i].s;
      inValid   = VECS[i].v;
      inLast    = VECS[i].l;
      inBytes   = VECS[i].n;
      bigEndian = VECS[i].be;
      inWord    = VECS[i].d;
      #1;
      check($sformatf("R%0d vec%0d ready", VECS[i].req, i), 64'(inReady), 64'(VECS[i].rdy));
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d qual", VECS[i].req, i), 64'(busQual), 64'(VECS[i].q));
      check($sformatf("R%0d vec%0d data", VECS[i].req, i), busData, VECS[i].x);
      check($sformatf("R10 vec%0d reserved", i),
            64'((busQual == 4'b0011) || (busQual[3:1] == 3'b011)), 64'h0);
    end

    // R1: reset in the middle of a packet
    @(negedge clk);
    rdStrobe = 1'b1; inValid = 1'b1; inLast = 1'b0; bigEndian = 1'b0; inWord = DW;
    @(posedge clk); #1;
    check("R3 pre-reset start", 64'(busQual), 64'h1);
    @(negedge clk);
    rst = 1'b1; rdStrobe = 1'b0;
    @(posedge clk); #1;
    check("R1 mid-packet reset qual", 64'(busQual), 64'h0);
    check("R1 mid-packet reset data", busData, 64'h0);
    @(negedge clk);
    rst = 1'b0; rdStrobe = 1'b1; inValid = 1'b1; inLast = 1'b0; inWord = EW;
    @(posedge clk); #1;
    check("R1 fresh start after reset", 64'(busQual), 64'h1);
    @(negedge clk);
    inLast = 1'b1; inBytes = 3'd0; inWord = DW;
    @(posedge clk); #1;
    check("R5 full end qual", 64'(busQual), 64'h8);
    check("R5 full end data", busData, DW);
    @(negedge clk);
    rdStrobe = 1'b0; inValid = 1'b0; inLast = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R2 long hold", 64'(busQual), 64'h8);

    finishRun();
  end

endmodule